// File: doc/BRIEF.md
# Line-Grouped Reorder Buffer

This block keeps program order for an out-of-order core at the granularity of decode groups, not single operations. Each cycle the decoder may hand over a group of up to three operations with a per-slot valid mask. The whole group takes one buffer line, and its line index is returned to the front end. Execution units report completions out of order through several completion ports. Each port names a line and a slot within that line.

The oldest line leaves the buffer as a unit once every slot its mask marks valid has reported done. At most one line leaves per cycle, and lines leave in the order they were allocated. A one-cycle retire pulse carries the line index and the line's valid mask. A flush input discards every line at once and returns both ring pointers to line zero.

Top module: `lgrob`

## Requirements
- R1: While `full` is low and `flush` is low, a high `alloc_req` takes the line shown on `alloc_line` at the clock edge, and `alloc_line` then moves to the next line index, wrapping from 23 back to 0.
- R2: A completion port with `cpl_vld` high marks slot `cpl_slot` (0..2) of line `cpl_line` as done at the clock edge. Several ports may complete slots of the same line in one cycle.
- R3: A line leaves only when it is the oldest occupied line and every slot whose `alloc_mask` bit was 1 at allocation is done. Slots whose mask bit was 0 need no completion.
- R4: Lines leave in allocation order, at most one per cycle. Each departure raises `ret_vld` for one cycle with `ret_line` equal to the line index and `ret_mask` equal to its allocation mask.
- R5: `ret_vld` for a line rises no earlier than the second clock edge after the edge that allocated it, or that recorded its last completion. A line allocated with mask 0 leaves at the edge right after its allocation edge.
- R6: With all 24 lines occupied, `full` is high and `alloc_req` is ignored: `alloc_line` does not move, and no line is written.
- R7: A completion that names a line not occupied at that edge has no effect, including on a later allocation of that line.
- R8: A `flush` edge empties every line, returns `alloc_line` to 0 and `full` to low, and holds `ret_vld` low in the following cycle. Completions for the discarded lines then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all lines and reset pointers |
| alloc_req | input | 1 | Request a line for a decode group |
| alloc_mask | input | SLOTS | Valid slots of the group (bit i = slot i) |
| full | output | 1 | All lines occupied; allocation stalled |
| alloc_line | output | clog2(LINES) | Line the next group receives |
| cpl_vld | input | CPL | Per-port completion strobe |
| cpl_line | input | CPL*clog2(LINES) | Per-port line index, port p at bits [p*5 +: 5] |
| cpl_slot | input | CPL*clog2(SLOTS) | Per-port slot index, port p at bits [p*2 +: 2] |
| ret_vld | output | 1 | One-cycle retire pulse |
| ret_line | output | clog2(LINES) | Index of the retiring line |
| ret_mask | output | SLOTS | Valid mask of the retiring line |

## Verification
The bench goes through all eight slot masks and finishes completions in reverse slot order. A design that retired on a partial mask, or that waited on empty slots, would leave too early or hang. Younger lines are completed ahead of the head to catch a design that retires out of order or drops one of a burst of back-to-back departures. Completions aimed at a line before it is allocated, or after a flush, must leave no trace. A design that did not gate on occupancy would retire those lines early. The ring is filled to 24 lines, with an allocation tried while full. A design that overwrote the head would retire a wrong mask or one line too many, and a design with a wrong wrap would return a wrong `alloc_line`.

// File: rtl/lgrob_pkg.sv
package lgrob_pkg;
  localparam int unsigned DEF_LINES = 24;
  localparam int unsigned DEF_SLOTS = 3;
  localparam int unsigned DEF_CPL   = 3;

  // next index on a ring of n entries
  function automatic int unsigned ring_next(input int unsigned v, input int unsigned n);
    return (v + 1 == n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/lgrob_ring.sv
module lgrob_ring
  import lgrob_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  localparam int unsigned LW = $clog2(LINES),
  localparam int unsigned CW = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic [LW-1:0] head,
  output logic [LW-1:0] tail,
  output logic          full
);
  logic [LW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) tail_d = LW'(ring_next(int'(tail_q), LINES));
      if (pop)  head_d = LW'(ring_next(int'(head_q), LINES));
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign en = flush | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign full = (cnt_q == CW'(LINES));
endmodule

// File: rtl/lgrob_cpl_dec.sv
module lgrob_cpl_dec
  import lgrob_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned CPL   = DEF_CPL,
  localparam int unsigned LW = $clog2(LINES),
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic [CPL-1:0]         cpl_vld,
  input  logic [CPL*LW-1:0]      cpl_line,
  input  logic [CPL*SW-1:0]      cpl_slot,
  input  logic [LINES-1:0]       occ,
  output logic [LINES*SLOTS-1:0] hit
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic match;
      always_comb begin
        match = 1'b0;
        for (int p = 0; p < CPL; p++) begin
          if (cpl_vld[p] && (cpl_line[p*LW +: LW] == LW'(l)) &&
              (cpl_slot[p*SW +: SW] == SW'(s)))
            match = 1'b1;
        end
      end
      // completions to lines that are not occupied are dropped
      assign hit[l*SLOTS + s] = match & occ[l];
    end
  end
endmodule

// File: rtl/lgrob_line.sv
module lgrob_line
  import lgrob_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc,
  input  logic [SLOTS-1:0] alloc_mask,
  input  logic             retire,
  input  logic [SLOTS-1:0] hit,
  output logic             occ,
  output logic [SLOTS-1:0] mask,
  output logic             ready
);
  logic             occ_q, occ_d;
  logic [SLOTS-1:0] mask_q, mask_d;
  logic [SLOTS-1:0] done_q, done_d;
  logic             en;

  always_comb begin
    occ_d  = occ_q;
    mask_d = mask_q;
    done_d = done_q;
    if (flush) begin
      occ_d  = 1'b0;
      done_d = '0;
    end else if (retire) begin
      occ_d  = 1'b0;
    end else if (alloc) begin
      occ_d  = 1'b1;
      mask_d = alloc_mask;
      done_d = '0;
    end else begin
      done_d = done_q | hit;
    end
  end

  assign en = flush | retire | alloc | (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= 1'b0;
      mask_q <= '0;
      done_q <= '0;
    end else if (en) begin
      occ_q  <= occ_d;
      mask_q <= mask_d;
      done_q <= done_d;
    end
  end

  assign occ   = occ_q;
  assign mask  = mask_q;
  // empty slots count as complete
  assign ready = occ_q & (&(done_q | ~mask_q));
endmodule

// File: rtl/lgrob.sv
module lgrob
  import lgrob_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned CPL   = DEF_CPL
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              alloc_req,
  input  logic [SLOTS-1:0]                  alloc_mask,
  output logic                              full,
  output logic [$clog2(LINES)-1:0]          alloc_line,
  input  logic [CPL-1:0]                    cpl_vld,
  input  logic [CPL*$clog2(LINES)-1:0]      cpl_line,
  input  logic [CPL*$clog2(SLOTS)-1:0]      cpl_slot,
  output logic                              ret_vld,
  output logic [$clog2(LINES)-1:0]          ret_line,
  output logic [SLOTS-1:0]                  ret_mask
);
  localparam int unsigned LW = $clog2(LINES);

  logic [LW-1:0]          head, tail;
  logic                   full_w;
  logic [LINES-1:0]       occ, ready;
  logic [LINES*SLOTS-1:0] mask_flat, hit_flat;
  logic                   alloc_fire, ret_fire;

  logic                   ret_vld_q, ret_vld_d;
  logic [LW-1:0]          ret_line_q, ret_line_d;
  logic [SLOTS-1:0]       ret_mask_q, ret_mask_d;

  assign alloc_fire = alloc_req & ~full_w & ~flush;
  assign ret_fire   = ready[head] & ~flush;

  lgrob_ring #(.LINES(LINES)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (alloc_fire),
    .pop   (ret_fire),
    .head  (head),
    .tail  (tail),
    .full  (full_w)
  );

  lgrob_cpl_dec #(.LINES(LINES), .SLOTS(SLOTS), .CPL(CPL)) u_dec (
    .cpl_vld  (cpl_vld),
    .cpl_line (cpl_line),
    .cpl_slot (cpl_slot),
    .occ      (occ),
    .hit      (hit_flat)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    lgrob_line #(.SLOTS(SLOTS)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc      (alloc_fire && (tail == LW'(l))),
      .alloc_mask (alloc_mask),
      .retire     (ret_fire && (head == LW'(l))),
      .hit        (hit_flat[l*SLOTS +: SLOTS]),
      .occ        (occ[l]),
      .mask       (mask_flat[l*SLOTS +: SLOTS]),
      .ready      (ready[l])
    );
  end

  always_comb begin
    ret_vld_d  = ret_fire;
    ret_line_d = ret_line_q;
    ret_mask_d = ret_mask_q;
    if (ret_fire) begin
      ret_line_d = head;
      ret_mask_d = mask_flat[int'(head)*SLOTS +: SLOTS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_vld_q <= 1'b0;
    end else begin
      ret_vld_q <= ret_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_line_q <= '0;
      ret_mask_q <= '0;
    end else if (ret_fire) begin
      ret_line_q <= ret_line_d;
      ret_mask_q <= ret_mask_d;
    end
  end

  assign full       = full_w;
  assign alloc_line = tail;
  assign ret_vld    = ret_vld_q;
  assign ret_line   = ret_line_q;
  assign ret_mask   = ret_mask_q;
endmodule

// File: rtl/lgrob_chk.sv
module lgrob_chk #(
  parameter int unsigned LINES = 24,
  localparam int unsigned LW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          alloc_req,
  input logic          full,
  input logic [LW-1:0] alloc_line,
  input logic          ret_vld,
  input logic [LW-1:0] ret_line
);
  function automatic logic [LW-1:0] nxt(input logic [LW-1:0] v);
    return (v == LW'(LINES - 1)) ? '0 : v + LW'(1);
  endfunction

  // R1: an accepted allocation advances the tail by one, with wrap
  a_r1_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !full && !flush) |=> (alloc_line == nxt($past(alloc_line))));

  // R6: a full buffer keeps its tail
  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush) |=> $stable(alloc_line));

  // R8: flush empties the buffer and silences retirement
  a_r8_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!ret_vld && !full && (alloc_line == '0)));

  // R4: back-to-back departures are consecutive lines
  a_r4_ret_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && $past(ret_vld)) |-> (ret_line == nxt($past(ret_line))));
endmodule

bind lgrob lgrob_chk #(.LINES(LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .alloc_req  (alloc_req),
  .full       (full),
  .alloc_line (alloc_line),
  .ret_vld    (ret_vld),
  .ret_line   (ret_line)
);

// File: tb/lgrob_bench.sv
`timescale 1ns/1ps
module lgrob_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        alloc_req;
  logic [2:0]  alloc_mask;
  logic        full;
  logic [4:0]  alloc_line;
  logic [2:0]  cpl_vld;
  logic [14:0] cpl_line;
  logic [5:0]  cpl_slot;
  logic        ret_vld;
  logic [4:0]  ret_line;
  logic [2:0]  ret_mask;

  int tests = 0, fails = 0, cyc = 0, nlog = 0;
  int log_line [128];
  int log_mask [128];
  int log_cyc  [128];
  bit finished = 1'b0;

  lgrob u_lgrob (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_req(alloc_req), .alloc_mask(alloc_mask), .full(full), .alloc_line(alloc_line),
    .cpl_vld(cpl_vld), .cpl_line(cpl_line), .cpl_slot(cpl_slot),
    .ret_vld(ret_vld), .ret_line(ret_line), .ret_mask(ret_mask)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && ret_vld && nlog < 128) begin
      log_line[nlog] = int'(ret_line);
      log_mask[nlog] = int'(ret_mask);
      log_cyc[nlog]  = cyc;
      nlog++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic alloc(input logic [2:0] m);
    alloc_req = 1'b1; alloc_mask = m;
    tick(1);
    alloc_req = 1'b0; alloc_mask = '0;
  endtask

  task automatic set_cpl(input int p, input int l, input int s);
    cpl_vld[p] = 1'b1;
    cpl_line[p*5 +: 5] = l[4:0];
    cpl_slot[p*2 +: 2] = s[1:0];
  endtask

  task automatic clr_cpl();
    cpl_vld = '0; cpl_line = '0; cpl_slot = '0;
  endtask

  task automatic cpl_one(input int l, input int s);
    set_cpl(0, l, s); tick(1); clr_cpl();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 1'b0; flush = 1'b0; alloc_req = 1'b0; alloc_mask = '0;
    clr_cpl();
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(full == 1'b0, "R6 reset full", int'(full), 0);
    chk(alloc_line == 5'd0, "R1 reset alloc_line", int'(alloc_line), 0);
    chk(nlog == 0, "R4 reset no retire", nlog, 0);

    // every mask, completions in reverse slot order (lines 0..7)
    for (int m = 0; m < 8; m++) begin
      n0 = nlog;
      alloc(m[2:0]);
      chk(int'(alloc_line) == m + 1, "R1 advance", int'(alloc_line), m + 1);
      if (m == 0) begin
        tick(1);
        chk(nlog == n0, "R5 no retire in alloc cycle", nlog, n0);
        tick(1);
      end else begin
        for (int s = 2; s >= 0; s--) begin
          if (m[s]) begin
            cpl_one(m, s);
            tick(1);
            chk(nlog == n0, "R3 R5 wait for slots", nlog, n0);
            if ((m & ((1 << s) - 1)) == 0) tick(1);
          end
        end
      end
      chk(nlog == n0 + 1, "R3 retired once", nlog, n0 + 1);
      chk(log_line[n0] == m, "R4 ret_line", log_line[n0], m);
      chk(log_mask[n0] == m, "R4 ret_mask", log_mask[n0], m);
    end

    // order: lines 8,9,10; younger ones complete first
    n0 = nlog;
    alloc(3'b111); alloc(3'b111); alloc(3'b111);
    for (int s = 0; s < 3; s++) set_cpl(s, 9, s);
    tick(1); clr_cpl();
    for (int s = 0; s < 3; s++) set_cpl(s, 10, s);
    tick(1); clr_cpl();
    tick(3);
    chk(nlog == n0, "R3 head blocks younger", nlog, n0);
    for (int s = 0; s < 3; s++) set_cpl(s, 8, s);   // R2 three ports at once
    tick(1); clr_cpl();
    tick(4);
    chk(nlog == n0 + 3, "R2 R4 burst retire", nlog, n0 + 3);
    for (int i = 0; i < 3; i++) begin
      chk(log_line[n0+i] == 8 + i, "R4 order", log_line[n0+i], 8 + i);
      chk(log_mask[n0+i] == 7, "R4 mask", log_mask[n0+i], 7);
    end
    chk(log_cyc[n0+1] == log_cyc[n0] + 1, "R4 one per cycle", log_cyc[n0+1] - log_cyc[n0], 1);
    chk(log_cyc[n0+2] == log_cyc[n0+1] + 1, "R4 one per cycle", log_cyc[n0+2] - log_cyc[n0+1], 1);

    // completion before allocation is dropped (line 11)
    n0 = nlog;
    cpl_one(11, 0);
    alloc(3'b001);
    tick(4);
    chk(nlog == n0, "R7 early completion ignored", nlog, n0);
    cpl_one(11, 0);
    tick(2);
    chk(nlog == n0 + 1 && log_line[n0] == 11, "R7 real completion", log_line[n0], 11);

    // flush (lines 12,13 discarded)
    n0 = nlog;
    alloc(3'b001); alloc(3'b001);
    flush = 1'b1; tick(1); flush = 1'b0;
    chk(alloc_line == 5'd0, "R8 tail reset", int'(alloc_line), 0);
    chk(full == 1'b0, "R8 not full", int'(full), 0);
    set_cpl(0, 12, 0); set_cpl(1, 13, 0); set_cpl(2, 0, 0);
    tick(1); clr_cpl();
    tick(4);
    chk(nlog == n0, "R8 discarded lines silent", nlog, n0);

    // fill all 24 lines from 0
    n0 = nlog;
    for (int i = 0; i < 24; i++) begin
      alloc(3'b001);
      if (i == 22) chk(full == 1'b0, "R6 not yet full", int'(full), 0);
    end
    chk(full == 1'b1, "R6 full", int'(full), 1);
    chk(alloc_line == 5'd0, "R1 wrap", int'(alloc_line), 0);
    alloc(3'b010);
    chk(alloc_line == 5'd0, "R6 stalled alloc", int'(alloc_line), 0);
    chk(full == 1'b1, "R6 still full", int'(full), 1);
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 3; p++) set_cpl(p, 3*k + p, 0);
      tick(1); clr_cpl();
    end
    tick(30);
    chk(nlog == n0 + 24, "R6 exactly 24 retired", nlog - n0, 24);
    for (int i = 0; i < 24; i++) begin
      chk(log_line[n0+i] == i && log_mask[n0+i] == 1, "R4 R6 drain", log_line[n0+i], i);
    end
    chk(full == 1'b0, "R6 drained", int'(full), 0);
    alloc(3'b100);
    chk(alloc_line == 5'd1, "R1 reuse line 0", int'(alloc_line), 1);
    cpl_one(0, 2);
    tick(2);
    chk(nlog == n0 + 25 && log_line[n0+24] == 0, "R1 reuse retire", log_line[n0+24], 0);
    chk(log_mask[n0+24] == 4, "R4 reuse mask", log_mask[n0+24], 4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule